// File: doc/BRIEF.md
# Sticky Masked Receiver Error Register

This block gathers per-frame error and status indications from a bi-phase digital audio receiver and keeps them in one status register that a host can read. Each condition (parity error, bi-phase coding error, loss of clock-recovery lock, and the received validity flag) can set its own status bit. A confidence bit is derived from the bi-phase error and unlock conditions together. Once set, a bit stays set until the host reads the status register, and that read clears it. The register therefore logs every enabled condition seen since the previous read.

A host-writable enable register, with one bit per status bit, decides which conditions are logged. A 1 enables the condition and a 0 suppresses it. An interrupt output is high while any logged and enabled bit is set. The host reaches both registers through a parallel strobe port. The read data is combinational from the selected register. A read strobe at the status address clears the log on the following clock edge.

Top module: `rxerr_log`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0 and `irq` is low.
- R2: A condition whose enable bit is 0 never sets its status bit.
- R3: An enabled condition present at a clock edge sets its bit from that edge on. Bit layout: bit 0 parity, bit 1 bi-phase, bit 2 confidence, bit 3 validity, bit 4 unlock.
- R4: The confidence bit (bit 2) is set when a bi-phase error or an unlock occurs and bit 2 is enabled, whatever the enables of bits 1 and 4.
- R5: A set status bit stays set while no clearing read occurs, even after its condition goes away.
- R6: A read strobe at address 0 presents the logged bits on `reg_rdata` in that cycle and clears them at the clock edge.
- R7: An enabled condition that arrives in the same cycle as a clearing read is set after that read.
- R8: `irq` is high exactly when some status bit is set and its enable bit is 1. It goes low after a clearing read, or when the enable is withdrawn.
- R9: A write at address 1 loads the enable register from `reg_wdata[4:0]`. Bits above bit 4 read as zero, and a write at address 0 changes neither register.
- R10: The validity bit (bit 3) is logged while `rx_valid_flag` is high and bit 3 is enabled.
- R11: A read at address 1 returns the enable register and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_unlock | input | 1 | Clock-recovery lock lost |
| rx_biphase_err | input | 1 | Bi-phase coding error |
| rx_parity_err | input | 1 | Parity error |
| rx_valid_flag | input | 1 | Received validity flag |
| reg_addr | input | ADDR_W (2) | Register address: 0 status, 1 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears the status register when addressed) |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data of the addressed register |
| irq | output | 1 | High while an enabled status bit is set |

## Verification
A status bit that is stuck, lost or set without cause shows up on `reg_rdata` at status address 0 on the first clock edge after the stimulus, and on `irq` in the same cycle. A clear that is missing or lands in the wrong cycle shows up one edge after the read strobe. At that point the register must hold only the conditions that arrived during the read. A corrupted enable register shows up when it is read back at address 1, and also as conditions that are dropped or wrongly logged on the next event.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int NBITS   = 5;
  localparam int B_PAR   = 0;
  localparam int B_BIP   = 1;
  localparam int B_CONF  = 2;
  localparam int B_VALID = 3;
  localparam int B_UNLK  = 4;

  typedef logic [NBITS-1:0] errvec_t;

  // Compose the raw event vector from the receiver indications.
  function automatic errvec_t f_event_vec(input logic unlock, input logic bip,
                                          input logic par, input logic valid);
    errvec_t v;
    v          = '0;
    v[B_PAR]   = par;
    v[B_BIP]   = bip;
    v[B_CONF]  = bip | unlock;
    v[B_VALID] = valid;
    v[B_UNLK]  = unlock;
    return v;
  endfunction

  // Next value of one sticky bit.
  function automatic logic f_sticky_next(input logic cur, input logic ev,
                                         input logic en, input logic clr);
    return (cur & ~clr) | (ev & en);
  endfunction
endpackage

// File: rtl/rxerr_evmap.sv
module rxerr_evmap
  import rxerr_pkg::*;
(
  input  logic    unlock,
  input  logic    bip,
  input  logic    par,
  input  logic    valid,
  output errvec_t ev_vec
);
  always_comb ev_vec = f_event_vec(unlock, bip, par, valid);
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky
  import rxerr_pkg::*;
#(
  parameter int N = NBITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_vec,
  input  logic [N-1:0] en_vec,
  input  logic         clr,
  output logic [N-1:0] status
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= f_sticky_next(bit_q, ev_vec[i], en_vec[i], clr);
    end
    assign status[i] = bit_q;
  end
endmodule

// File: rtl/rxerr_regs.sv
module rxerr_regs #(
  parameter int N      = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N-1:0]      status,
  output logic [N-1:0]      en_vec,
  output logic              clr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(1);
  localparam int               PAD      = DATA_W - N;

  logic [N-1:0] en_q;
  logic         sel_status, sel_enable;

  assign sel_status = (reg_addr == A_STATUS);
  assign sel_enable = (reg_addr == A_ENABLE);

  always_ff @(posedge clk) begin
    if (!rst_n)                    en_q <= '0;
    else if (reg_wr && sel_enable) en_q <= reg_wdata[N-1:0];
  end

  assign en_vec = en_q;
  assign clr    = reg_rd & sel_status;

  always_comb begin
    reg_rdata = '0;
    if (sel_status)      reg_rdata = {{PAD{1'b0}}, status};
    else if (sel_enable) reg_rdata = {{PAD{1'b0}}, en_q};
  end
endmodule

// File: rtl/rxerr_log.sv
module rxerr_log
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_unlock,
  input  logic              rx_biphase_err,
  input  logic              rx_parity_err,
  input  logic              rx_valid_flag,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  errvec_t ev_vec;
  errvec_t en_vec;
  errvec_t status;
  logic    rd_clr;

  rxerr_evmap u_evmap (
    .unlock (rx_unlock),
    .bip    (rx_biphase_err),
    .par    (rx_parity_err),
    .valid  (rx_valid_flag),
    .ev_vec (ev_vec)
  );

  rxerr_sticky #(.N(NBITS)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_vec (ev_vec),
    .en_vec (en_vec),
    .clr    (rd_clr),
    .status (status)
  );

  rxerr_regs #(.N(NBITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .status    (status),
    .en_vec    (en_vec),
    .clr       (rd_clr),
    .reg_rdata (reg_rdata)
  );

  assign irq = |(status & en_vec);
endmodule

// File: rtl/rxerr_log_chk.sv
module rxerr_log_chk #(
  parameter int N      = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      ev_vec,
  input logic [N-1:0]      en_vec,
  input logic [N-1:0]      status,
  input logic              rd_clr,
  input logic              rx_unlock,
  input logic              rx_biphase_err,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);
  // R2: a newly set bit must have been enabled in the previous cycle
  p_no_masked_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(en_vec)) == '0));

  // R3: an enabled event is present after the edge
  p_set_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_vec & en_vec) != '0) |=> ((status & $past(ev_vec & en_vec)) == $past(ev_vec & en_vec)));

  // R4: confidence follows bi-phase or unlock
  p_conf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_unlock || rx_biphase_err) && en_vec[2]) |=> status[2]);

  // R5: no clear, no loss
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((status & $past(status)) == $past(status)));

  // R6, R7: after a clearing read only same-cycle events remain
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (status == $past(ev_vec & en_vec)));

  // R8: quiet read drops the interrupt
  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ((ev_vec & en_vec) == '0)) |=> !irq);

  // R9: unused read bits are zero
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:N] == '0);
endmodule

bind rxerr_log rxerr_log_chk #(.N(rxerr_pkg::NBITS), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_vec         (ev_vec),
  .en_vec         (en_vec),
  .status         (status),
  .rd_clr         (rd_clr),
  .rx_unlock      (rx_unlock),
  .rx_biphase_err (rx_biphase_err),
  .reg_rdata      (reg_rdata),
  .irq            (irq)
);

// File: tb/sim_rxerr_log.sv
`timescale 1ns/1ps
module sim_rxerr_log;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NROWS  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_unlock = 1'b0, rx_biphase_err = 1'b0;
  logic              rx_parity_err = 1'b0, rx_valid_flag = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  rxerr_log #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (.*);

  // row: enable[4:0], unlock, bip, par, valid, rd, expected status[4:0]
  typedef struct packed {
    logic [4:0] en;
    logic       unl, bip, par, vld, rd;
    logic [4:0] exp;
  } row_t;

  localparam row_t TABLE [NROWS] = '{
    '{5'h1F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'h01}, // R3 parity -> bit 0
    '{5'h1F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h06}, // R3 R4 bi-phase -> bits 1,2
    '{5'h1F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h14}, // R3 R4 unlock -> bits 4,2
    '{5'h1F, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'h08}, // R10 validity -> bit 3
    '{5'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'h00}, // R2 all disabled
    '{5'h04, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'h04}, // R4 conf only
    '{5'h04, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'h04}, // R4 conf only
    '{5'h1B, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5'h1B}, // R2 conf disabled
    '{5'h1F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 5'h07}, // R7 event during read
    '{5'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'h01}  // R2 R10 validity disabled
  };

  task automatic check(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_en(input logic [DATA_W-1:0] v);
    reg_addr = 2'd1; reg_wdata = v; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic events(input logic u, input logic b, input logic p, input logic v,
                        input logic rd);
    rx_unlock = u; rx_biphase_err = b; rx_parity_err = p; rx_valid_flag = v;
    reg_addr = 2'd0; reg_rd = rd;
    tick();
    rx_unlock = 0; rx_biphase_err = 0; rx_parity_err = 0; rx_valid_flag = 0;
    reg_rd = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    reg_addr = 2'd0; #1;
    check("R1 status", reg_rdata, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    reg_addr = 2'd1; #1;
    check("R1 enable", reg_rdata, 8'h00);
    reg_addr = 2'd0;

    for (int i = 0; i < NROWS; i++) begin
      set_en({3'b0, TABLE[i].en});
      events(TABLE[i].unl, TABLE[i].bip, TABLE[i].par, TABLE[i].vld, TABLE[i].rd);
      #1;
      check($sformatf("R3 row %0d status", i), reg_rdata, {3'b0, TABLE[i].exp});
      check($sformatf("R8 row %0d irq", i), {7'b0, irq}, {7'b0, |TABLE[i].exp});
      events(0, 0, 0, 0, 1'b1); // clear for the next row
    end

    // R5 sticky after the event has gone
    set_en(8'h1F);
    events(0, 0, 1, 0, 0);
    repeat (3) tick();
    #1;
    check("R5 sticky", reg_rdata, 8'h01);

    // R11 enable read leaves status alone
    reg_addr = 2'd1; reg_rd = 1'b1; #1;
    check("R11 enable readback", reg_rdata, 8'h1F);
    tick();
    reg_rd = 1'b0; reg_addr = 2'd0; #1;
    check("R11 status kept", reg_rdata, 8'h01);

    // R6 read shows data in the cycle, clears at the edge
    reg_addr = 2'd0; reg_rd = 1'b1; #1;
    check("R6 read data", reg_rdata, 8'h01);
    tick();
    reg_rd = 1'b0; #1;
    check("R6 cleared", reg_rdata, 8'h00);
    check("R8 irq after clear", {7'b0, irq}, 8'h00);

    // R8 withdrawing the enable drops irq, status remains
    events(0, 1, 0, 0, 0);
    #1;
    check("R8 irq set", {7'b0, irq}, 8'h01);
    set_en(8'h00);
    #1;
    check("R8 irq masked", {7'b0, irq}, 8'h00);
    check("R8 status kept", reg_rdata, 8'h06);

    // R9 write at address 0 ignored; upper bits read zero
    reg_addr = 2'd0; reg_wdata = 8'hFF; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; #1;
    check("R9 status unaffected", reg_rdata, 8'h06);
    reg_addr = 2'd1; #1;
    check("R9 enable unaffected", reg_rdata, 8'h00);
    set_en(8'hFF);
    reg_addr = 2'd1; #1;
    check("R9 upper bits zero", reg_rdata, 8'h1F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule